// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a 32-bit virtual address into a physical address through a single-level page table held in ordinary word-addressed memory. A client presents a virtual address together with an access kind (read, write or execute). The unit takes the upper 20 bits as a page index and the lower 12 bits as the byte offset within a 4096-byte page. It reads the entry for that page over a simple request/response memory port, checks the entry's valid bit and its permission field, and answers with either a physical address or a fault cause.

When a successful read or write access changes the entry's referenced or modified status bit, the unit writes the updated entry back to the same memory word before it answers. The base address of the table is loaded through a small configuration port. The unit handles one translation at a time and stays busy until that translation has been answered.

Top module: `pat_unit`

## Requirements
- R1: The physical address is the 20-bit frame number from the entry placed above the unchanged 12-bit offset. Virtual 0x13325328 with frame 0x03004 gives 0x03004328. Virtual 9000 (page 2) with frame 4 gives 17192.
- R2: The entry is read from table base + page index * 4. The base comes from `cfg_base` on a cycle with `cfg_load` high, and a new base applies to later translations.
- R3: Entry bit layout (bit 24 down to bit 0): valid at 24, referenced at 23, modified at 22, permission at 21:20, frame number at 19:0. Bits 31:25 are carried unchanged. If the valid bit is clear, the answer is cause 1 with physical address 0, and no write-back occurs.
- R4: Access kind encoding: 0 read, 1 write, 2 execute. Permission encoding: 00 read only, 01 read/write, 10 read/execute, 11 read/write/execute. A disallowed access answers cause 2 with physical address 0. Cause 0 means success. Cause 3 never appears.
- R5: A successful read or write sets the referenced bit. Only a successful write sets the modified bit. An execute access changes neither bit.
- R6: A write-back is issued only when the entry's value actually changes, and never on a faulting access. It goes to the address the entry was read from, and it carries the updated entry.
- R7: `req_ready` is low from the accepting edge until the answer. `rsp_valid` is a single-cycle pulse. With a memory that is always ready and answers on the next cycle, the answer is due 3 cycles after the accepting edge without a write-back and 4 cycles after it with one.
- R8: After reset, `req_ready` is high, no memory request and no answer are pending, and the table base is 0.
- R9: A memory request that is not yet accepted holds `mem_req_valid`, its address, its data and its direction stable until `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load the table base register |
| cfg_base | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation answer, one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_cause | output | 2 | 0 none, 1 invalid page, 2 protection |

## Verification
The bench's memory model is ready by default and returns read data on the cycle after it accepts a request. An answer is therefore due 3 cycles after the accepting edge, or 4 cycles when a write-back is inserted. Each translation task counts falling edges from the acceptance until `rsp_valid` appears and compares that count with 3 or 4, chosen from whether the expected entry changes. While it waits, the task checks that `req_ready` stays low. One falling edge after the answer, it checks that the pulse has ended. Write-backs are counted and compared in the memory model when they are accepted, and the stall scenario holds `mem_req_ready` low and samples the request fields on every falling edge of the stall.

// File: rtl/pat_pkg.sv
// Shared encodings for the paged address translation unit.
// Assumes: access kinds and fault causes fit in two bits.
package pat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_PROT    = 2'd2
    } cause_t;
endpackage

// File: rtl/pat_base_reg.sv
// Table base register, loaded from the configuration port.
// Assumes: the software side keeps the base word aligned.
module pat_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] base
);
    // Hold the base; clear on reset, replace on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    base <= '0;
        else if (load) base <= load_val;
    end
endmodule

// File: rtl/pat_check.sv
// Combinational entry check: validity, permission and status update.
// Assumes: the entry fields sit just above the frame number, as set by PAGE_W.
module pat_check
    import pat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGE_W = 20
) (
    input  logic [DATA_W-1:0] entry,
    input  acc_t              kind,
    output cause_t            cause,
    output logic [DATA_W-1:0] new_entry,
    output logic              changed
);
    localparam int PROT_LO = PAGE_W;
    localparam int MOD_BIT = PAGE_W + 2;
    localparam int REF_BIT = PAGE_W + 3;
    localparam int VAL_BIT = PAGE_W + 4;

    logic [1:0] prot;
    logic       allowed;

    // Decide whether the permission field admits the access kind.
    always_comb begin
        prot = entry[PROT_LO+1:PROT_LO];
        case (kind)
            ACC_READ:  allowed = 1'b1;
            ACC_WRITE: allowed = prot[0];
            ACC_EXEC:  allowed = prot[1];
            default:   allowed = 1'b0;
        endcase
    end

    // Pick the fault cause; an invalid page outranks a permission miss.
    always_comb begin
        if (!entry[VAL_BIT])  cause = CAUSE_INVALID;
        else if (!allowed)    cause = CAUSE_PROT;
        else                  cause = CAUSE_NONE;
    end

    // Build the updated entry and flag a real change.
    always_comb begin
        new_entry = entry;
        if (kind == ACC_READ || kind == ACC_WRITE) new_entry[REF_BIT] = 1'b1;
        if (kind == ACC_WRITE)                     new_entry[MOD_BIT] = 1'b1;
        changed = (new_entry != entry);
    end
endmodule

// File: rtl/pat_seq.sv
// Translation sequencer: accept, fetch entry, optional write-back, answer.
// Assumes: memory returns exactly one read response per accepted read and
// needs no response for a write.
module pat_seq
    import pat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output acc_t              chk_kind,
    input  cause_t            chk_cause,
    input  logic [DATA_W-1:0] chk_new,
    input  logic              chk_changed,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_cause
);
    localparam int PAGE_W  = ADDR_W - OFF_W;
    localparam int REF_BIT = PAGE_W + 3;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_WAIT, S_WB, S_RESP
    } state_t;

    state_t             st;
    logic [ADDR_W-1:0]  addr_q;
    logic [OFF_W-1:0]   off_q;
    acc_t               kind_q;
    logic [DATA_W-1:0]  entry_q;
    logic [DATA_W-1:0]  new_q;
    cause_t             cause_q;
    logic [ADDR_W-1:0]  paddr_q;

    // Advance the transaction and capture its operands and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            kind_q  <= ACC_READ;
            entry_q <= '0;
            new_q   <= '0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    addr_q <= base + ADDR_W'({req_vaddr[ADDR_W-1:OFF_W], 2'b00});
                    off_q  <= req_vaddr[OFF_W-1:0];
                    kind_q <= acc_t'(req_kind);
                    st     <= S_FETCH;
                end
                S_FETCH: if (mem_req_ready) st <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    entry_q <= mem_rsp_rdata;
                    new_q   <= chk_new;
                    cause_q <= chk_cause;
                    paddr_q <= (chk_cause == CAUSE_NONE)
                             ? {mem_rsp_rdata[PAGE_W-1:0], off_q} : '0;
                    st      <= (chk_cause == CAUSE_NONE && chk_changed) ? S_WB : S_RESP;
                end
                S_WB:   if (mem_req_ready) st <= S_RESP;
                S_RESP: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Drive the port signals from the current state.
    always_comb begin
        req_ready     = (st == S_IDLE);
        mem_req_valid = (st == S_FETCH) || (st == S_WB);
        mem_req_write = (st == S_WB);
        mem_req_addr  = addr_q;
        mem_req_wdata = new_q;
        rsp_valid     = (st == S_RESP);
        rsp_paddr     = paddr_q;
        rsp_cause     = cause_q;
        chk_kind      = kind_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_WB_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata != entry_q); // R6
    AST_WB_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> cause_q == CAUSE_NONE); // R6
    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[REF_BIT]); // R5
    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_cause != 2'd3); // R4
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause != 2'd0 |-> rsp_paddr == '0); // R3
endmodule

// File: rtl/pat_unit.sv
// Paged address translation unit top: base register, sequencer, entry check.
// Assumes: one translation in flight; the table is a flat array of 32-bit entries.
module pat_unit
    import pat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_cause
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] base;
    acc_t              chk_kind;
    cause_t            chk_cause;
    logic [DATA_W-1:0] chk_new;
    logic              chk_changed;

    pat_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val(cfg_base), .base(base)
    );

    pat_check #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_check (
        .entry(mem_rsp_rdata), .kind(chk_kind), .cause(chk_cause),
        .new_entry(chk_new), .changed(chk_changed)
    );

    pat_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .base(base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .chk_kind(chk_kind), .chk_cause(chk_cause),
        .chk_new(chk_new), .chk_changed(chk_changed),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> req_ready && !mem_req_valid && !rsp_valid); // R8
endmodule

// File: tb/test_pat_unit.sv
// Directed bench for pat_unit: one task per scenario, each checking its results.
module test_pat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int fails  = 0;
    int wb_count = 0;
    int cyc = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] mem_words [int unsigned];

    always #2 clk = ~clk;

    pat_unit i_pat_unit (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
    );

    // Memory model: accepts when ready, answers reads on the next cycle.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_words[mem_req_addr] = mem_req_wdata;
                wb_count++;
            end else begin
                last_rd_addr  <= mem_req_addr;
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_words.exists(mem_req_addr) ? mem_words[mem_req_addr] : '0;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input bit v, input bit r, input bit m,
                                       input logic [1:0] p, input logic [19:0] f);
        return {7'd0, v, r, m, p, f};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        cfg_load = 1'b1; cfg_base = b;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // One translation; checks busy, latency, pulse and write-back count.
    task automatic xlate(input string tag, input logic [31:0] va, input logic [1:0] kind,
                         input logic [31:0] exp_pa, input logic [1:0] exp_cause,
                         input bit exp_wb);
        int lat = 0;
        int wb0;
        bit busy_ok = 1'b1;
        @(negedge clk);
        wb0 = wb_count;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk({tag, " R1 paddr"}, rsp_paddr, exp_pa);
        chk({tag, " R4 cause"}, 32'(rsp_cause), 32'(exp_cause));
        if (mem_req_ready) chk({tag, " R7 latency"}, lat, exp_wb ? 4 : 3);
        chk({tag, " R7 busy"}, 32'(busy_ok), 32'd1);
        @(negedge clk);
        chk({tag, " R7 pulse"}, 32'(rsp_valid), 32'd0);
        chk({tag, " R6 writebacks"}, wb_count - wb0, exp_wb ? 1 : 0);
    endtask

    task automatic t_reset();
        chk("R8 req_ready", 32'(req_ready), 32'd1);
        chk("R8 mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk("R8 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_examples();
        logic [31:0] a;
        set_base(32'h0010_0000);
        a = 32'h0010_0000 + 32'h13325 * 4;
        mem_words[a] = mk(1, 0, 0, 2'b01, 20'h03004);
        xlate("hex example", 32'h1332_5328, 2'd0, 32'h0300_4328, 2'd0, 1'b1);
        chk("R2 fetch address", last_rd_addr, a);
        chk("R5 ref set on read", mem_words[a], mk(1, 1, 0, 2'b01, 20'h03004));
        xlate("repeat read", 32'h1332_5328, 2'd0, 32'h0300_4328, 2'd0, 1'b0);
        mem_words[32'h0010_0008] = mk(1, 1, 0, 2'b00, 20'd4);
        xlate("decimal example", 32'd9000, 2'd0, 32'd17192, 2'd0, 1'b0);
    endtask

    task automatic t_write_status();
        logic [31:0] a = 32'h0010_0000 + 32'h40 * 4;
        mem_words[a] = {7'h55, 25'(mk(1, 1, 0, 2'b01, 20'hABCDE))};
        xlate("write sets mod", 32'h0004_0123, 2'd1, 32'hABCD_E123, 2'd0, 1'b1);
        chk("R5 R6 mod set, upper bits kept", mem_words[a],
            {7'h55, 25'(mk(1, 1, 1, 2'b01, 20'hABCDE))});
        xlate("repeat write", 32'h0004_0FFF, 2'd1, 32'hABCD_EFFF, 2'd0, 1'b0);
    endtask

    task automatic t_exec();
        logic [31:0] a = 32'h0010_0000 + 32'h41 * 4;
        mem_words[a] = mk(1, 0, 0, 2'b10, 20'h00777);
        xlate("exec on rx", 32'h0004_1010, 2'd2, 32'h0077_7010, 2'd0, 1'b0);
        chk("R5 exec leaves bits", mem_words[a], mk(1, 0, 0, 2'b10, 20'h00777));
        mem_words[a + 4] = mk(1, 0, 0, 2'b11, 20'h00888);
        xlate("exec on rwx", 32'h0004_2020, 2'd2, 32'h0088_8020, 2'd0, 1'b0);
    endtask

    task automatic t_protection();
        logic [31:0] a = 32'h0010_0000 + 32'h50 * 4;
        mem_words[a]     = mk(1, 0, 0, 2'b00, 20'h11111);
        mem_words[a + 4] = mk(1, 0, 0, 2'b01, 20'h22222);
        mem_words[a + 8] = mk(1, 0, 0, 2'b10, 20'h33333);
        xlate("R4 write on read-only", 32'h0005_0000, 2'd1, 32'h0, 2'd2, 1'b0);
        chk("R6 no wb on fault", mem_words[a], mk(1, 0, 0, 2'b00, 20'h11111));
        xlate("R4 exec on read/write", 32'h0005_1000, 2'd2, 32'h0, 2'd2, 1'b0);
        xlate("R4 write on read/exec", 32'h0005_2000, 2'd1, 32'h0, 2'd2, 1'b0);
    endtask

    task automatic t_invalid();
        logic [31:0] a = 32'h0010_0000 + 32'h60 * 4;
        mem_words[a] = mk(0, 0, 0, 2'b11, 20'h44444);
        xlate("R3 invalid read", 32'h0006_0ABC, 2'd0, 32'h0, 2'd1, 1'b0);
        xlate("R3 invalid write", 32'h0006_0ABC, 2'd1, 32'h0, 2'd1, 1'b0);
        chk("R3 entry untouched", mem_words[a], mk(0, 0, 0, 2'b11, 20'h44444));
    endtask

    task automatic t_rebase();
        set_base(32'h0020_0000);
        mem_words[32'h0020_0008] = mk(1, 1, 0, 2'b00, 20'h00009);
        xlate("R2 new base", 32'h0000_2004, 2'd0, 32'h0000_9004, 2'd0, 1'b0);
        chk("R2 fetch from new base", last_rd_addr, 32'h0020_0008);
    endtask

    task automatic t_stall();
        bit hold_ok = 1'b1;
        mem_words[32'h0020_000C] = mk(1, 1, 0, 2'b00, 20'h0000A);
        @(negedge clk);
        mem_req_ready = 1'b0;
        req_valid = 1'b1; req_vaddr = 32'h0000_3010; req_kind = 2'd0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!mem_req_valid || mem_req_write || mem_req_addr != 32'h0020_000C) hold_ok = 1'b0;
            @(negedge clk);
        end
        chk("R9 request held while stalled", 32'(hold_ok), 32'd1);
        mem_req_ready = 1'b1;
        for (int i = 0; i < 10 && !rsp_valid; i++) @(negedge clk);
        chk("R9 result after stall", rsp_paddr, 32'h0000_A010);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_write_status();
        t_exec();
        t_protection();
        t_invalid();
        t_rebase();
        t_stall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule